// File: doc/BRIEF.md
# Context-Tagged Translation Cache with Least-Recently-Used Replacement

This block keeps a small, fully associative cache of virtual-to-physical page number translations for one process at a time. A lookup presents a virtual page number and gets back, in the same cycle, a hit flag and the cached physical page number. Nothing enters the cache on a miss. The surrounding logic walks the page tables and then writes the result through the fill port. When a page is unmapped, an invalidate-one request removes its translation. A flush-all command empties the cache.

The block records which process it serves. A fill that carries a different process identifier first empties every entry, then stores the new identifier and the new translation. Each entry carries a last-use stamp taken from a free-running access counter. When no entry is free, a fill replaces the entry with the oldest stamp. Creating a new mapping in the page tables does not involve this block, because only the fill port writes entries.

Top module: `ctx_tlb`

## Requirements
- R1: After reset every entry is invalid, the recorded process identifier is 0 and the access counter is 0, so every lookup misses.
- R2: A lookup of a valid tag raises `lookupHit` combinationally in the same cycle and drives that entry's physical page number on `lookupPpn`. When `lookupHit` is low, `lookupPpn` is 0.
- R3: A lookup that misses changes no entry, so repeating it still misses.
- R4: A fill of a tag that is not yet cached is written to the lowest-numbered invalid entry. If every entry is valid, it replaces the entry with the smallest stamp, and on equal stamps the lowest index wins. The victim is chosen from the stamps held before the current cycle.
- R5: The access counter advances by one in each cycle that has a lookup or an accepted fill. A lookup hit stamps the hit entry, and a fill stamps the written entry, with the counter value before that advance.
- R6: A fill whose tag is already cached under the same process rewrites that entry's physical page number and stamp in place, so no tag is ever held twice.
- R7: An invalidate clears the entry that holds `invVpn`. When no entry holds it, nothing changes.
- R8: A flush clears every entry.
- R9: A fill whose `fillPid` differs from the recorded identifier clears all entries, records `fillPid` and writes the translation into entry 0. A fill with the same identifier clears nothing.
- R10: A lookup reports a miss if, in the same cycle, a flush is requested or an accepted invalidate names the same tag. Otherwise the lookup sees the entries as they stood before the clock edge.
- R11: Only one write operation takes effect per cycle. Flush has the highest priority, then invalidate, then fill, and the lower-priority requests in that cycle are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lookupValid | input | 1 | Lookup request |
| lookupVpn | input | VPN_W | Virtual page number to translate |
| lookupHit | output | 1 | Lookup found a valid translation |
| lookupPpn | output | PPN_W | Translated physical page number, 0 on miss |
| fillValid | input | 1 | Fill request after a page table walk |
| fillPid | input | PID_W | Process identifier of the fill |
| fillVpn | input | VPN_W | Virtual page number to store |
| fillPpn | input | PPN_W | Physical page number to store |
| invValid | input | 1 | Invalidate-one request |
| invVpn | input | VPN_W | Virtual page number to remove |
| flushValid | input | 1 | Clear all entries |

## Verification
The cache is first filled through its free entries in order, so each tag's position is known. Then one entry is touched and a ninth tag is filled, so the bench can tell which entry was evicted. This shows whether the block evicts by true recency or by fill order. A refill of a cached tag shows that the entry is updated in place: the eight entries stay intact and the new page number appears. Lookups are paired with invalidates of the same tag and of a different tag, and fills are paired with flushes and invalidates, to separate the same-cycle priorities. Fills that alternate between process identifiers show whether a context change empties the cache and whether a fill from the same process leaves it intact. A long random mix over a small tag range and a few process identifiers keeps the cache full and the evictions frequent. Throughout, the outputs are compared with a behavioural model on every clock.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  // Strobes from control to datapath for one cycle
  typedef struct packed {
    logic clearAll;     // drop every entry (flush or context change)
    logic clearOne;     // accepted invalidate of one tag
    logic writeEntry;   // accepted fill
    logic ctxSwitch;    // fill carries a new process identifier
    logic advance;      // access counter steps this cycle
    logic lookupBlock;  // lookup forced to miss by a flush
  } tlbStrobe_t;

endpackage

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N_ENTRIES = 8,
  parameter int STAMP_W   = 16,
  parameter int IDX_W     = 3
) (
  input  logic [N_ENTRIES-1:0]              validVec,
  input  logic [N_ENTRIES-1:0][STAMP_W-1:0] stampVec,
  output logic [IDX_W-1:0]                  victimIdx
);

  logic             freeFound;
  logic [IDX_W-1:0] freeIdx;
  logic [IDX_W-1:0] oldIdx;

  // Lowest-numbered free entry
  always_comb begin
    freeFound = 1'b0;
    freeIdx   = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (!validVec[i]) begin
        freeFound = 1'b1;
        freeIdx   = IDX_W'(i);
      end
    end
  end

  // Smallest stamp; a strict compare keeps the lowest index on a tie
  always_comb begin
    oldIdx = '0;
    for (int i = 1; i < N_ENTRIES; i++) begin
      if (stampVec[i] < stampVec[oldIdx]) oldIdx = IDX_W'(i);
    end
  end

  assign victimIdx = freeFound ? freeIdx : oldIdx;

endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
#(
  parameter int PID_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lookupValid,
  input  logic             fillValid,
  input  logic [PID_W-1:0] fillPid,
  input  logic             invValid,
  input  logic             flushValid,
  output tlbStrobe_t       strobe
);

  logic [PID_W-1:0] curPidQ;
  logic             doInv;
  logic             doFill;
  logic             ctxChange;

  // Priority: flush, then invalidate, then fill
  always_comb begin
    doInv     = invValid & ~flushValid;
    doFill    = fillValid & ~flushValid & ~invValid;
    ctxChange = doFill & (fillPid != curPidQ);

    strobe.clearAll    = flushValid | ctxChange;
    strobe.clearOne    = doInv;
    strobe.writeEntry  = doFill;
    strobe.ctxSwitch   = ctxChange;
    strobe.advance     = lookupValid | doFill;
    strobe.lookupBlock = flushValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curPidQ <= '0;
    end else if (ctxChange) begin
      curPidQ <= fillPid;
    end
  end

  AST_PID_TRACKS_FILL: assert property (@(posedge clk) disable iff (!rstN)
    fillValid && !invValid && !flushValid |=> curPidQ == $past(fillPid)); // R9

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({flushValid, strobe.clearOne, strobe.writeEntry})); // R11

  AST_FLUSH_DROPS_FILL: assert property (@(posedge clk) disable iff (!rstN)
    flushValid && fillValid |=> $stable(curPidQ)); // R11

endmodule

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int VPN_W     = 20,
  parameter int PPN_W     = 20,
  parameter int STAMP_W   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tlbStrobe_t       strobe,
  input  logic             lookupValid,
  input  logic [VPN_W-1:0] lookupVpn,
  input  logic [VPN_W-1:0] invVpn,
  input  logic [VPN_W-1:0] fillVpn,
  input  logic [PPN_W-1:0] fillPpn,
  output logic             lookupHit,
  output logic [PPN_W-1:0] lookupPpn
);

  localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;

  logic [N_ENTRIES-1:0]              validQ;
  logic [N_ENTRIES-1:0][STAMP_W-1:0] stampQ;
  logic [VPN_W-1:0]                  vpnQ [N_ENTRIES];
  logic [PPN_W-1:0]                  ppnQ [N_ENTRIES];
  logic [STAMP_W-1:0]                counterQ;

  logic [N_ENTRIES-1:0] lookMatch;
  logic [N_ENTRIES-1:0] fillMatch;
  logic [N_ENTRIES-1:0] invMatch;
  logic [IDX_W-1:0]     fillMatchIdx;
  logic [IDX_W-1:0]     victimIdx;
  logic [IDX_W-1:0]     fillIdx;
  logic [PPN_W-1:0]     hitPpn;
  logic                 invKill;

  // Parallel tag compare against every valid entry
  always_comb begin
    for (int i = 0; i < N_ENTRIES; i++) begin
      lookMatch[i] = validQ[i] && (vpnQ[i] == lookupVpn);
      fillMatch[i] = validQ[i] && (vpnQ[i] == fillVpn);
      invMatch[i]  = validQ[i] && (vpnQ[i] == invVpn);
    end
  end

  always_comb begin
    fillMatchIdx = '0;
    hitPpn       = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (fillMatch[i]) fillMatchIdx = IDX_W'(i);
      if (lookMatch[i]) hitPpn = hitPpn | ppnQ[i];
    end
  end

  tlb_victim #(
    .N_ENTRIES (N_ENTRIES),
    .STAMP_W   (STAMP_W),
    .IDX_W     (IDX_W)
  ) uVictim (
    .validVec  (validQ),
    .stampVec  (stampQ),
    .victimIdx (victimIdx)
  );

  always_comb begin
    if (strobe.ctxSwitch)  fillIdx = '0;
    else if (|fillMatch)   fillIdx = fillMatchIdx;
    else                   fillIdx = victimIdx;
  end

  assign invKill   = strobe.clearOne && (invVpn == lookupVpn);
  assign lookupHit = lookupValid && (|lookMatch) && !strobe.lookupBlock && !invKill;
  assign lookupPpn = lookupHit ? hitPpn : '0;

  // Valid bits, stamps and access counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ   <= '0;
      stampQ   <= '0;
      counterQ <= '0;
    end else begin
      if (strobe.advance) counterQ <= counterQ + 1'b1;
      for (int i = 0; i < N_ENTRIES; i++) begin
        if (strobe.writeEntry && fillIdx == IDX_W'(i)) begin
          validQ[i] <= 1'b1;
          stampQ[i] <= counterQ;
        end else if (strobe.clearAll) begin
          validQ[i] <= 1'b0;
        end else if (strobe.clearOne && invMatch[i]) begin
          validQ[i] <= 1'b0;
        end else if (lookupHit && lookMatch[i]) begin
          stampQ[i] <= counterQ;
        end
      end
    end
  end

  // Translation payload carries no reset; validQ guards it
  always_ff @(posedge clk) begin
    if (strobe.writeEntry) begin
      vpnQ[fillIdx] <= fillVpn;
      ppnQ[fillIdx] <= fillPpn;
    end
  end

  function automatic logic tagPresent(input logic [VPN_W-1:0] tag);
    logic found;
    found = 1'b0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (validQ[i] && vpnQ[i] == tag) found = 1'b1;
    end
    return found;
  endfunction

  AST_UNIQUE_TAG: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lookMatch)); // R6

  AST_MISS_PPN_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !lookupHit |-> lookupPpn == '0); // R2

  AST_MISS_NO_INSERT: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid && !lookupHit && !strobe.writeEntry |=> !tagPresent($past(lookupVpn))); // R3

  AST_FILL_PRESENT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.writeEntry |=> tagPresent($past(fillVpn))); // R4

  AST_INV_GONE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearOne |=> !tagPresent($past(invVpn))); // R7

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearAll && !strobe.writeEntry |=> validQ == '0); // R8

  AST_CTX_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ctxSwitch |=> $onehot(validQ)); // R9

  AST_INV_BEATS_LOOKUP: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid && strobe.clearOne && invVpn == lookupVpn |-> !lookupHit); // R10

endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb
  import tlb_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int VPN_W     = 20,
  parameter int PPN_W     = 20,
  parameter int PID_W     = 16,
  parameter int STAMP_W   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lookupValid,
  input  logic [VPN_W-1:0] lookupVpn,
  output logic             lookupHit,
  output logic [PPN_W-1:0] lookupPpn,
  input  logic             fillValid,
  input  logic [PID_W-1:0] fillPid,
  input  logic [VPN_W-1:0] fillVpn,
  input  logic [PPN_W-1:0] fillPpn,
  input  logic             invValid,
  input  logic [VPN_W-1:0] invVpn,
  input  logic             flushValid
);

  tlbStrobe_t strobe;

  tlb_ctrl #(
    .PID_W (PID_W)
  ) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .lookupValid (lookupValid),
    .fillValid   (fillValid),
    .fillPid     (fillPid),
    .invValid    (invValid),
    .flushValid  (flushValid),
    .strobe      (strobe)
  );

  tlb_datapath #(
    .N_ENTRIES (N_ENTRIES),
    .VPN_W     (VPN_W),
    .PPN_W     (PPN_W),
    .STAMP_W   (STAMP_W)
  ) uData (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .lookupValid (lookupValid),
    .lookupVpn   (lookupVpn),
    .invVpn      (invVpn),
    .fillVpn     (fillVpn),
    .fillPpn     (fillPpn),
    .lookupHit   (lookupHit),
    .lookupPpn   (lookupPpn)
  );

endmodule

// File: tb/tb_ctx_tlb.sv
module tb_ctx_tlb;

  localparam int CLK_PERIOD = 10;
  localparam int NE = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lookupValid = 1'b0;
  logic [19:0] lookupVpn = '0;
  logic        lookupHit;
  logic [19:0] lookupPpn;
  logic        fillValid = 1'b0;
  logic [15:0] fillPid = '0;
  logic [19:0] fillVpn = '0;
  logic [19:0] fillPpn = '0;
  logic        invValid = 1'b0;
  logic [19:0] invVpn = '0;
  logic        flushValid = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Behavioural reference state
  bit mValid [NE];
  int mVpn   [NE];
  int mPpn   [NE];
  int mStamp [NE];
  int mPid = 0;
  int mCnt = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ctx_tlb dut (
    .clk(clk), .rstN(rstN),
    .lookupValid(lookupValid), .lookupVpn(lookupVpn),
    .lookupHit(lookupHit), .lookupPpn(lookupPpn),
    .fillValid(fillValid), .fillPid(fillPid), .fillVpn(fillVpn), .fillPpn(fillPpn),
    .invValid(invValid), .invVpn(invVpn), .flushValid(flushValid)
  );

  task automatic report(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // One clock: drive, compare against the model, advance the model
  task automatic cycle(input bit lv, input int lvpn, input bit fv, input int fpid,
                       input int fvpn, input int fppn, input bit iv, input int ivpn,
                       input bit fl, input string tag);
    int hitIdx;
    bit expHit;
    int expPpn;
    int tgt;
    lookupValid = lv; lookupVpn = 20'(lvpn);
    fillValid = fv; fillPid = 16'(fpid); fillVpn = 20'(fvpn); fillPpn = 20'(fppn);
    invValid = iv; invVpn = 20'(ivpn); flushValid = fl;
    #1;
    hitIdx = -1;
    for (int i = 0; i < NE; i++) if (mValid[i] && mVpn[i] == lvpn) hitIdx = i;
    expHit = lv && hitIdx >= 0 && !fl && !(iv && ivpn == lvpn);
    expPpn = expHit ? mPpn[hitIdx] : 0;
    report(tag, "lookupHit", int'(lookupHit), int'(expHit));
    report(tag, "lookupPpn", int'(lookupPpn), expPpn);
    // fill target from pre-cycle state
    tgt = -1;
    if (fv && !fl && !iv) begin
      if (fpid == mPid) begin
        for (int i = 0; i < NE; i++) if (mValid[i] && mVpn[i] == fvpn) tgt = i;
        if (tgt < 0) for (int i = NE - 1; i >= 0; i--) if (!mValid[i]) tgt = i;
        if (tgt < 0) begin
          tgt = 0;
          for (int i = 1; i < NE; i++) if (mStamp[i] < mStamp[tgt]) tgt = i;
        end
      end else begin
        tgt = 0;
      end
    end
    if (expHit) mStamp[hitIdx] = mCnt;
    if (fl) begin
      for (int i = 0; i < NE; i++) mValid[i] = 0;
    end else if (iv) begin
      for (int i = 0; i < NE; i++) if (mValid[i] && mVpn[i] == ivpn) mValid[i] = 0;
    end else if (fv) begin
      if (fpid != mPid) begin
        for (int i = 0; i < NE; i++) mValid[i] = 0;
        mPid = fpid;
      end
      mValid[tgt] = 1; mVpn[tgt] = fvpn; mPpn[tgt] = fppn; mStamp[tgt] = mCnt;
    end
    if (lv || (fv && !fl && !iv)) mCnt++;
    @(posedge clk);
    @(negedge clk);
    lookupValid = 0; fillValid = 0; invValid = 0; flushValid = 0;
  endtask

  task automatic look(input int vpn, input bit eh, input int ep, input string tag);
    lookupValid = 1; lookupVpn = 20'(vpn);
    #1;
    report(tag, "hardHit", int'(lookupHit), int'(eh));
    report(tag, "hardPpn", int'(lookupPpn), eh ? ep : 0);
    cycle(1, vpn, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic fill(input int pid, input int vpn, input int ppn, input string tag);
    cycle(0, 0, 1, pid, vpn, ppn, 0, 0, 0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NE; i++) begin mValid[i] = 0; mStamp[i] = 0; end
    repeat (3) @(negedge clk);
    report("R1", "hitInReset", int'(lookupHit), 0);
    rstN = 1;
    @(negedge clk);
    // R1 reset: empty cache
    look(5, 0, 0, "R1");
    // R3 miss inserts nothing
    look(7, 0, 0, "R3");
    look(7, 0, 0, "R3");
    // R4 fills go to free entries; R2 hits return ppn
    for (int v = 1; v <= 8; v++) fill(0, v, 100 + v, "R4");
    for (int v = 1; v <= 8; v++) look(v, 1, 100 + v, "R2");
    // R5 touch vpn1, vpn2 is now oldest and gets evicted
    look(1, 1, 101, "R5");
    fill(0, 9, 109, "R4");
    look(2, 0, 0, "R5");
    look(1, 1, 101, "R5");
    look(9, 1, 109, "R4");
    // R6 refill in place
    fill(0, 3, 333, "R6");
    look(3, 1, 333, "R6");
    for (int v = 4; v <= 9; v++) look(v, 1, 100 + v, "R6");
    look(1, 1, 101, "R6");
    // R7 invalidate of absent tag, then present tag
    cycle(0, 0, 0, 0, 0, 0, 1, 50, 0, "R7");
    for (int v = 3; v <= 9; v++) look(v, 1, (v == 3) ? 333 : 100 + v, "R7");
    cycle(0, 0, 0, 0, 0, 0, 1, 4, 0, "R7");
    look(4, 0, 0, "R7");
    // R10 same-cycle invalidate beats lookup of same tag only
    cycle(1, 5, 0, 0, 0, 0, 1, 5, 0, "R10");
    look(5, 0, 0, "R10");
    cycle(1, 6, 0, 0, 0, 0, 1, 7, 0, "R10");
    look(6, 1, 106, "R10");
    look(7, 0, 0, "R10");
    // R11 flush drops fill; R8 flush empties
    cycle(1, 6, 1, 0, 20, 120, 0, 0, 1, "R11");
    look(20, 0, 0, "R11");
    for (int v = 1; v <= 9; v++) look(v, 0, 0, "R8");
    // R9 context change flushes, same pid does not
    fill(0, 30, 130, "R9");
    fill(0, 31, 131, "R9");
    fill(1, 32, 132, "R9");
    look(30, 0, 0, "R9");
    look(31, 0, 0, "R9");
    look(32, 1, 132, "R9");
    fill(1, 33, 133, "R9");
    look(32, 1, 132, "R9");
    look(33, 1, 133, "R9");
    // R11 invalidate beats fill
    cycle(0, 0, 1, 1, 34, 134, 1, 32, 0, "R11");
    look(34, 0, 0, "R11");
    look(32, 0, 0, "R11");
    look(33, 1, 133, "R11");
    // R10 flush kills concurrent lookup
    cycle(1, 33, 0, 0, 0, 0, 0, 0, 1, "R10");
    look(33, 0, 0, "R8");
    // Random mix against the model
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      cycle($urandom_range(0, 99) < 70, int'($urandom_range(0, 11)),
            r < 35, (r < 3) ? int'($urandom_range(0, 2)) : mPid,
            int'($urandom_range(0, 11)), int'($urandom_range(0, 4095)),
            r >= 90, int'($urandom_range(0, 11)), r == 99, "R2");
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule